// File: doc/BRIEF.md
# NAND Byte-Bus Burst Engine

This block moves bursts of 1 to 32 bytes between a 32-entry byte buffer and an 8-bit NAND flash or LCD-type byte bus. Software fills or drains the buffer through a small register window, sets the direction, length and strobe pacing, and starts a burst. The engine then drives the active-low write or read strobe for each byte without further software help.

Every strobe pulse lasts a programmable number of wait states plus one system clock cycle. Before each byte the engine holds until the device ready line is high. Chip enable can stay under software control, or the engine can drive it, either for the whole burst or separately around each byte. Command and address latch lines stay with software. When the burst ends, a sticky done flag is set, and if enabled it raises the interrupt line.

Top module: `nbb_burst_engine`

## Requirements
- R1: While reset is held and after it is released, nf_ce_n, nf_we_n and nf_re_n are 1, nf_dq_oe and irq are 0, and the status register (address 3) reads 0.
- R2: A burst transfers exactly LEN+1 bytes, where LEN is bits 4:0 of address 1. The range is 1 to 32 bytes.
- R3: Each strobe is low for exactly WAIT+1 cycles, where WAIT is bits 5:0 of address 2. It is then high for at least two cycles before the next strobe, and the two strobes are never low together.
- R4: In a write burst (address 0 bit 0 = 1), the byte on nf_dq_o at the k-th falling edge of nf_we_n is buffer entry k. nf_dq_oe is 1 only while a write burst is running.
- R5: In a read burst (address 0 bit 0 = 0), the value on nf_dq_i in the last low cycle of the k-th read strobe is stored in buffer entry k.
- R6: No strobe begins unless nf_rdy was high in the cycle before. While nf_rdy is low the engine waits indefinitely.
- R7: Address 0 bit 1 = 0 gives software chip enable, where nf_ce_n is the inverse of bit 4. Bit 1 = 1 with bit 2 = 0 holds nf_ce_n low from start to the end of the last byte. Bit 1 = 1 with bit 2 = 1 pulls nf_ce_n low around each strobe only and releases it between bytes.
- R8: The end of a burst sets status bit 1 (done), which stays set until a write to address 3 with bit 1 = 1. irq equals done AND address 0 bit 3.
- R9: Writing address 3 with bit 0 = 1 starts a burst only when the engine is idle. Status bit 0 (busy) reads 1 from the start until the last byte finishes. A start written during a burst is ignored.
- R10: Address 4 holds the buffer index and address 5 reads or writes the buffer entry at that index. While a burst runs, index, buffer and configuration writes (addresses 0, 1, 2, 4, 5) are ignored, and reads of address 5 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the strobe timing base |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Register access select |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Burst-complete interrupt request |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Bus data out |
| nf_dq_oe | output | 1 | Bus driver enable |
| nf_dq_i | input | 8 | Bus data in |
| nf_rdy | input | 1 | Device ready, high = ready |

## Verification
A sequencer stuck in a wrong state shows up within one strobe period. The strobe width or the high gap between strobes goes wrong, or the two strobes overlap, and the bench measures all of these on every byte. A wrong byte counter or buffer pointer shows up by the end of the burst as a wrong number of strobes, misordered write data, or read-back buffer entries that do not match what the device model supplied. A bad done, busy or interrupt state is visible at the status register and the irq pin as soon as the burst ends. A missing ready or idle gate shows up as strobes during a held-off ready line, or as a doubled burst length.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_READY   = 2'd1,
    S_STROBE  = 2'd2,
    S_RECOVER = 2'd3
  } seq_state_e;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_LEN   = 3'd1;
  localparam logic [2:0] A_WAIT  = 3'd2;
  localparam logic [2:0] A_CMD   = 3'd3;
  localparam logic [2:0] A_INDEX = 3'd4;
  localparam logic [2:0] A_DATA  = 3'd5;

  typedef struct packed {
    logic sw_ce;
    logic irq_en;
    logic ce_per_byte;
    logic ce_auto;
    logic dir_wr;
  } ctrl_t;
endpackage

// File: rtl/nbb_buffer.sv
module nbb_buffer #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [DW-1:0]    rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [DW-1:0]    rd_b_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_a_data = mem[rd_a_idx];
  assign rd_b_data = mem[rd_b_idx];
endmodule

// File: rtl/nbb_regs.sv
module nbb_regs
  import nbb_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int WAIT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [2:0]        host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              busy,
  input  logic              done_set,
  input  logic [BYTE_W-1:0] buf_rd_data,
  output ctrl_t             ctrl,
  output logic [IDX_W-1:0]  len_m1,
  output logic [WAIT_W-1:0] wait_n,
  output logic              start,
  output logic              done,
  output logic              irq,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              buf_wr_en,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [BYTE_W-1:0] buf_wr_data
);
  ctrl_t             ctrl_d;
  logic [IDX_W-1:0]  len_d;
  logic [WAIT_W-1:0] wait_d;
  logic [IDX_W-1:0]  idx_d;
  logic              done_d;
  logic              wr_any;
  logic              wr_cfg;

  assign wr_any = host_sel & host_wr;
  assign wr_cfg = wr_any & ~busy;

  // next-state
  always_comb begin
    ctrl_d = ctrl;
    len_d  = len_m1;
    wait_d = wait_n;
    idx_d  = buf_idx;
    if (wr_cfg) begin
      case (host_addr)
        A_CTRL:  ctrl_d = ctrl_t'(host_wdata[4:0]);
        A_LEN:   len_d  = host_wdata[IDX_W-1:0];
        A_WAIT:  wait_d = host_wdata[WAIT_W-1:0];
        A_INDEX: idx_d  = host_wdata[IDX_W-1:0];
        default: ;
      endcase
    end
    done_d = done;
    if (wr_any && host_addr == A_CMD && host_wdata[1]) begin
      done_d = 1'b0;
    end
    if (done_set) begin
      done_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      len_m1  <= '0;
      wait_n  <= '0;
      buf_idx <= '0;
      done    <= 1'b0;
    end else begin
      ctrl    <= ctrl_d;
      len_m1  <= len_d;
      wait_n  <= wait_d;
      buf_idx <= idx_d;
      done    <= done_d;
    end
  end

  assign start       = wr_cfg && host_addr == A_CMD && host_wdata[0];
  assign buf_wr_en   = wr_cfg && host_addr == A_DATA;
  assign buf_wr_data = host_wdata;
  assign irq         = done & ctrl.irq_en;

  always_comb begin
    case (host_addr)
      A_CTRL:  host_rdata = BYTE_W'(ctrl);
      A_LEN:   host_rdata = BYTE_W'(len_m1);
      A_WAIT:  host_rdata = BYTE_W'(wait_n);
      A_CMD:   host_rdata = BYTE_W'({done, busy});
      A_INDEX: host_rdata = BYTE_W'(buf_idx);
      A_DATA:  host_rdata = busy ? '0 : buf_rd_data;
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/nbb_seq.sv
module nbb_seq
  import nbb_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int WAIT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_wr,
  input  logic [IDX_W-1:0]  len_m1,
  input  logic [WAIT_W-1:0] wait_n,
  input  logic              rdy,
  output seq_state_e        state,
  output logic [IDX_W-1:0]  byte_idx,
  output logic              capture,
  output logic              done_set,
  output logic              busy
);
  seq_state_e        state_d;
  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] cnt_d;
  logic [IDX_W-1:0]  idx_d;

  // next-state
  always_comb begin
    state_d  = state;
    cnt_d    = cnt_q;
    idx_d    = byte_idx;
    capture  = 1'b0;
    done_set = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          state_d = S_READY;
          idx_d   = '0;
        end
      end
      S_READY: begin
        if (rdy) begin
          state_d = S_STROBE;
          cnt_d   = wait_n;
        end
      end
      S_STROBE: begin
        if (cnt_q == '0) begin
          state_d = S_RECOVER;
          capture = ~dir_wr;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_RECOVER: begin
        if (byte_idx == len_m1) begin
          state_d  = S_IDLE;
          done_set = 1'b1;
        end else begin
          state_d = S_READY;
          idx_d   = byte_idx + 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt_q    <= '0;
      byte_idx <= '0;
    end else begin
      state    <= state_d;
      cnt_q    <= cnt_d;
      byte_idx <= idx_d;
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/nbb_burst_engine.sv
module nbb_burst_engine
  import nbb_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int WAIT_W    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic [2:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        irq,
  output logic        nf_ce_n,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic [7:0]  nf_dq_o,
  output logic        nf_dq_oe,
  input  logic [7:0]  nf_dq_i,
  input  logic        nf_rdy
);
  localparam int IDX_W = $clog2(BUF_DEPTH);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  ctrl_t             ctrl;
  logic [IDX_W-1:0]  len_m1;
  logic [WAIT_W-1:0] wait_n;
  logic              start;
  logic              done;
  logic              busy;
  logic              done_set;
  logic              capture;
  seq_state_e        state;
  logic [IDX_W-1:0]  byte_idx;
  logic              host_buf_we;
  logic [IDX_W-1:0]  host_idx;
  logic [7:0]        host_buf_wd;
  logic [7:0]        host_buf_rd;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_widx;
  logic [7:0]        mem_wd;
  logic              ce_auto_w;
  logic              ce_per_byte_w;
  logic              strobe_act;

  // reset: asserted asynchronously, released on clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  nbb_regs #(.IDX_W(IDX_W), .WAIT_W(WAIT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .busy       (busy),
    .done_set   (done_set),
    .buf_rd_data(host_buf_rd),
    .ctrl       (ctrl),
    .len_m1     (len_m1),
    .wait_n     (wait_n),
    .start      (start),
    .done       (done),
    .irq        (irq),
    .host_rdata (host_rdata),
    .buf_wr_en  (host_buf_we),
    .buf_idx    (host_idx),
    .buf_wr_data(host_buf_wd)
  );

  nbb_seq #(.IDX_W(IDX_W), .WAIT_W(WAIT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .dir_wr  (ctrl.dir_wr),
    .len_m1  (len_m1),
    .wait_n  (wait_n),
    .rdy     (nf_rdy),
    .state   (state),
    .byte_idx(byte_idx),
    .capture (capture),
    .done_set(done_set),
    .busy    (busy)
  );

  // engine capture and host writes are mutually exclusive (host gated by busy)
  assign mem_we   = capture | host_buf_we;
  assign mem_widx = capture ? byte_idx : host_idx;
  assign mem_wd   = capture ? nf_dq_i  : host_buf_wd;

  nbb_buffer #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W), .DW(BYTE_W)) u_buf (
    .clk      (clk),
    .wr_en    (mem_we),
    .wr_idx   (mem_widx),
    .wr_data  (mem_wd),
    .rd_a_idx (host_idx),
    .rd_a_data(host_buf_rd),
    .rd_b_idx (byte_idx),
    .rd_b_data(nf_dq_o)
  );

  assign ce_auto_w     = ctrl.ce_auto;
  assign ce_per_byte_w = ctrl.ce_per_byte;
  assign strobe_act    = (state == S_STROBE);

  assign nf_we_n  = ~(strobe_act &  ctrl.dir_wr);
  assign nf_re_n  = ~(strobe_act & ~ctrl.dir_wr);
  assign nf_dq_oe = busy & ctrl.dir_wr;

  always_comb begin
    if (!ce_auto_w) begin
      nf_ce_n = ~ctrl.sw_ce;
    end else if (ce_per_byte_w) begin
      nf_ce_n = ~(strobe_act | (state == S_RECOVER));
    end else begin
      nf_ce_n = ~busy;
    end
  end
endmodule

// File: rtl/nbb_burst_chk.sv
module nbb_burst_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic re_n,
  input logic dq_oe,
  input logic rdy,
  input logic busy,
  input logic ce_auto,
  input logic ce_per_byte
);
  // R3
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  // R3
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n && re_n) |=> (we_n && re_n));

  // R4
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  // R4
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> busy);

  // R6
  strobe_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n && re_n) |-> $past(rdy));

  // R7
  ce_per_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_auto && ce_per_byte && (!we_n || !re_n)) |-> !ce_n);

  // R7
  ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_auto && !busy) |-> ce_n);

  // R9
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> busy);
endmodule

bind nbb_burst_engine nbb_burst_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ce_n       (nf_ce_n),
  .we_n       (nf_we_n),
  .re_n       (nf_re_n),
  .dq_oe      (nf_dq_oe),
  .rdy        (nf_rdy),
  .busy       (busy),
  .ce_auto    (ce_auto_w),
  .ce_per_byte(ce_per_byte_w)
);

// File: tb/tb_nbb_burst_engine.sv
`timescale 1ns/1ps
module tb_nbb_burst_engine;
  logic       clk;
  logic       rst_n;
  logic       host_sel;
  logic       host_wr;
  logic [2:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       irq;
  logic       nf_ce_n;
  logic       nf_we_n;
  logic       nf_re_n;
  logic [7:0] nf_dq_o;
  logic       nf_dq_oe;
  logic [7:0] nf_dq_i;
  logic       nf_rdy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // monitor state
  logic       mon_en = 0;
  logic       mon_dir = 0;
  int         exp_w = 1;
  int         width = 0;
  int         nbytes = 0;
  int         width_err = 0;
  int         ce_rises = 0;
  int         oe_err = 0;
  logic [7:0] rd_base = 0;
  logic [7:0] wr_log [32];
  logic       prev_we = 1, prev_re = 1, prev_ce = 1;

  nbb_burst_engine dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .nf_ce_n(nf_ce_n), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rdy(nf_rdy)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // device model: byte k of a read burst
  assign nf_dq_i = rd_base ^ 8'(nbytes * 29);

  always @(negedge clk) begin
    if (mon_en) begin
      if (!nf_we_n || !nf_re_n) width++;
      if (prev_we && !nf_we_n && nbytes < 32) wr_log[nbytes] = nf_dq_o;
      if ((!prev_we && nf_we_n) || (!prev_re && nf_re_n)) begin
        if (width != exp_w) width_err++;
        width = 0;
        nbytes++;
      end
      if (!prev_ce && nf_ce_n) ce_rises++;
      if (nf_dq_oe && !mon_dir) oe_err++;
    end
    prev_we = nf_we_n;
    prev_re = nf_re_n;
    prev_ce = nf_ce_n;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog (R1..all) act=%0d cycles exp=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 0; host_addr = a;
    #1 d = host_rdata;
    host_sel = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    for (int i = 0; i < 20000; i++) begin
      hread(3'd3, st);
      if (!st[0]) break;
    end
  endtask

  task automatic mon_reset(input logic dir, input int w, input logic [7:0] base);
    @(negedge clk);
    width = 0; nbytes = 0; width_err = 0; ce_rises = 0; oe_err = 0;
    mon_dir = dir; exp_w = w; rd_base = base; mon_en = 1;
  endtask

  // vector table: dir(1=write), bytes, wait states, ce mode(0 sw,1 burst,2 per byte), irq_en, seed
  localparam int NV = 8;
  localparam int V_DIR [NV]  = '{1, 0, 1, 0, 1, 0, 1, 0};
  localparam int V_LEN [NV]  = '{1, 1, 32, 32, 5, 7, 3, 16};
  localparam int V_WAIT[NV]  = '{0, 0, 3, 1, 63, 63, 2, 0};
  localparam int V_CE  [NV]  = '{1, 2, 2, 1, 1, 0, 0, 2};
  localparam int V_IRQ [NV]  = '{1, 0, 1, 1, 0, 1, 0, 1};
  localparam int V_SEED[NV]  = '{11, 22, 33, 44, 55, 66, 77, 88};

  initial begin
    logic [7:0] rd;
    logic [7:0] ctrlv;
    int exp_rises;
    host_sel = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    nf_rdy = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(nf_ce_n == 1 && nf_we_n == 1 && nf_re_n == 1, "R1 strobes/ce in reset",
          {nf_ce_n, nf_we_n, nf_re_n}, 7);
    check(nf_dq_oe == 0 && irq == 0, "R1 oe/irq in reset", {nf_dq_oe, irq}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    hread(3'd3, rd);
    check(rd == 0, "R1 status after reset", rd, 0);
    check(nf_ce_n == 1 && nf_we_n == 1 && nf_re_n == 1 && nf_dq_oe == 0,
          "R1 bus idle after reset", {nf_ce_n, nf_we_n, nf_re_n, nf_dq_oe}, 14);

    // table walk
    for (int v = 0; v < NV; v++) begin
      if (V_DIR[v] == 1) begin
        for (int k = 0; k < V_LEN[v]; k++) begin
          hwrite(3'd4, 8'(k));
          hwrite(3'd5, 8'(V_SEED[v] + k * 7));
        end
      end
      hwrite(3'd1, 8'(V_LEN[v] - 1));
      hwrite(3'd2, 8'(V_WAIT[v]));
      ctrlv = 8'(V_DIR[v]);
      if (V_CE[v] != 0) ctrlv[1] = 1;
      if (V_CE[v] == 2) ctrlv[2] = 1;
      if (V_IRQ[v] != 0) ctrlv[3] = 1;
      if (V_CE[v] == 0) ctrlv[4] = 1;
      hwrite(3'd0, ctrlv);
      hwrite(3'd3, 8'h02);
      mon_reset(V_DIR[v] != 0, V_WAIT[v] + 1, 8'(V_SEED[v]));
      hwrite(3'd3, 8'h01);
      wait_idle();
      repeat (3) @(negedge clk);
      mon_en = 0;
      check(nbytes == V_LEN[v], $sformatf("R2 byte count vec %0d", v), nbytes, V_LEN[v]);
      check(width_err == 0, $sformatf("R3 strobe width errors vec %0d", v), width_err, 0);
      exp_rises = (V_CE[v] == 0) ? 0 : (V_CE[v] == 1) ? 1 : V_LEN[v];
      check(ce_rises == exp_rises, $sformatf("R7 ce releases vec %0d", v), ce_rises, exp_rises);
      if (V_CE[v] == 0)
        check(nf_ce_n == 0, $sformatf("R7 software ce level vec %0d", v), nf_ce_n, 0);
      check(oe_err == 0 && nf_dq_oe == 0, $sformatf("R4 driver enable vec %0d", v),
            oe_err + nf_dq_oe, 0);
      if (V_DIR[v] == 1) begin
        for (int k = 0; k < V_LEN[v]; k++)
          check(wr_log[k] == 8'(V_SEED[v] + k * 7), $sformatf("R4 write byte %0d vec %0d", k, v),
                wr_log[k], 8'(V_SEED[v] + k * 7));
      end else begin
        for (int k = 0; k < V_LEN[v]; k++) begin
          hwrite(3'd4, 8'(k));
          hread(3'd5, rd);
          check(rd == (8'(V_SEED[v]) ^ 8'(k * 29)), $sformatf("R5 read byte %0d vec %0d", k, v),
                rd, 8'(V_SEED[v]) ^ 8'(k * 29));
        end
      end
      hread(3'd3, rd);
      check(rd == 8'h02, $sformatf("R8 done set, R9 busy clear vec %0d", v), rd, 2);
      check(irq == (V_IRQ[v] != 0), $sformatf("R8 irq vec %0d", v), irq, V_IRQ[v]);
    end

    // ready stall, ignored start/config/buffer writes during a burst
    hwrite(3'd4, 8'd0); hwrite(3'd5, 8'h10);
    hwrite(3'd4, 8'd1); hwrite(3'd5, 8'h20);
    hwrite(3'd1, 8'd1);
    hwrite(3'd2, 8'd0);
    hwrite(3'd0, 8'h0B);
    hwrite(3'd3, 8'h02);
    nf_rdy = 0;
    mon_reset(1'b1, 1, 8'h00);
    hwrite(3'd3, 8'h01);
    repeat (20) @(negedge clk);
    check(nbytes == 0 && nf_we_n == 1, "R6 no strobe while not ready", nbytes, 0);
    hread(3'd3, rd);
    check(rd[0] == 1, "R9 busy during burst", rd[0], 1);
    hwrite(3'd3, 8'h01);
    hwrite(3'd4, 8'd0);
    hwrite(3'd5, 8'hEE);
    hwrite(3'd1, 8'd9);
    hread(3'd5, rd);
    check(rd == 0, "R10 data read during burst", rd, 0);
    nf_rdy = 1;
    wait_idle();
    repeat (3) @(negedge clk);
    mon_en = 0;
    check(nbytes == 2, "R9/R10 restart and length write ignored", nbytes, 2);
    check(wr_log[0] == 8'h10 && wr_log[1] == 8'h20, "R10 buffer write ignored",
          {wr_log[0], wr_log[1]}, 16'h1020);
    hread(3'd1, rd);
    check(rd == 1, "R10 length register unchanged", rd, 1);
    hread(3'd4, rd);
    check(rd == 1, "R10 index register unchanged", rd, 1);

    // done stays sticky, then clears on request
    repeat (10) @(negedge clk);
    hread(3'd3, rd);
    check(rd == 8'h02 && irq == 1, "R8 done sticky with irq", {rd, 7'd0, irq}, 16'h0201);
    hwrite(3'd3, 8'h02);
    hread(3'd3, rd);
    check(rd == 0 && irq == 0, "R8 done cleared", {rd, 7'd0, irq}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule